// File: doc/BRIEF.md
# Stream-Partitioned Nano-Cache Array

This block is a data-side cache front end built from seven small, independent nano-caches. Every load and store carries a 3-bit stream number chosen by software. A nonzero number picks one private nano-cache, so unrelated access streams such as separate arrays or the stack never evict each other's lines. Stream 0 is the default used when software gives no hint. It is the coherent path: it probes all seven nano-caches in the same cycle and uses a cached word only when exactly one nano-cache holds it.

Stores are always written through to the next memory level. A store under a nonzero stream also updates its own nano-cache. A store under stream 0 removes every matching copy. The next-level port carries one request at a time. The request side stays not-ready while a miss or a store is being serviced, so a later read can never overtake a write that is still in flight. A flush input clears one nano-cache in a single cycle. Software uses it when it stops using a stream.

The reset input is asynchronous and active-low. Inside the block its release is synchronised to the clock.

Top module: `snc_array`

## Requirements
- R1: Two cycles after the reset input is released, req_ready is 1, and resp_valid and mem_req_valid are 0.
- R2: A read miss under stream s (1..7) sends one next-level read for its address. It returns the next-level data and allocates the word only in nano-cache s. A repeat read under s then hits without any next-level request.
- R3: A word held in nano-cache a is not visible to a read under a different nonzero stream b. That read misses.
- R4: A stream 0 read whose address is held in exactly one nano-cache returns that copy and sends no next-level request.
- R5: A stream 0 read whose address is held in zero nano-caches, or in more than one, fetches from the next level. No line is allocated, so a repeat stream 0 read of the same address misses again.
- R6: A write under stream s (1..7) issues a next-level write with its address and data and produces no response. Nano-cache s then holds the new data; other nano-caches keep whatever they held.
- R7: A write under stream 0 issues a next-level write and invalidates the matching line in every nano-cache.
- R8: mem_req_valid is a one-cycle pulse. At most one next-level request is outstanding. req_ready is 0 from the cycle after a miss or write is accepted until the cycle after mem_ack, so a read issued after a write returns the written data.
- R9: A one-cycle flush_valid with flush_stream = s (1..7) clears every line of nano-cache s and leaves the others intact. flush_stream = 0 has no effect.
- R10: A read hit raises resp_valid with its data in the cycle after the request is accepted (valid and ready both high at a clock edge). A miss responds in the cycle after mem_ack.
- R11: Each nano-cache is direct-mapped with 4 one-word lines indexed by address bits [1:0]; the remaining address bits form the tag. Two addresses with equal index and different tags evict each other within one stream. Addresses with different indices coexist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Store data |
| req_stream | input | 3 | Stream number (0 = coherent default) |
| resp_valid | output | 1 | Load data valid (one cycle) |
| resp_rdata | output | 32 | Load data |
| flush_valid | input | 1 | Flush one nano-cache |
| flush_stream | input | 3 | Nano-cache to flush (0 = none) |
| mem_req_valid | output | 1 | Next-level request pulse |
| mem_req_write | output | 1 | Next-level request is a write |
| mem_req_addr | output | 8 | Next-level word address |
| mem_req_wdata | output | 32 | Next-level write data |
| mem_ack | input | 1 | Next-level completion pulse |
| mem_rdata | input | 32 | Next-level read data, valid with mem_ack |

## Verification
Some properties are checked on every cycle. A hit accepted at one edge yields a response and no next-level request at the next edge. A stream 0 read that sees several holders always goes to the next level. Next-level requests are single-cycle pulses, and req_ready is low while one is in flight. Inside each nano-cache, a flush, a fill or an invalidate takes effect one cycle later. Other behaviours can only be shown by the bench's scenarios, which track a reference model of every partition. These include stale copies left in other partitions after a private store, the absence of allocation under stream 0, eviction between conflicting tags, and read-after-write ordering through the next level.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } snc_state_e;

endpackage

// File: rtl/snc_part.sv
module snc_part #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic              inv_en,
  input  logic              flush_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;
  logic             upd_match;
  logic             line_wr;

  assign lk_idx  = lk_addr[IDX_W-1:0];
  assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
  assign upd_idx = upd_addr[IDX_W-1:0];
  assign upd_tag = upd_addr[ADDR_W-1:IDX_W];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = data_q[lk_idx];

  assign upd_match = vld_q[upd_idx] && (tag_q[upd_idx] == upd_tag);
  assign line_wr   = fill_en && !flush_en;

  // next state of the valid bits: flush wins over fill and invalidate
  always_comb begin
    vld_d = vld_q;
    if (flush_en) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[upd_idx] = 1'b1;
    end else if (inv_en && upd_match) begin
      vld_d[upd_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic wr_line;
    assign wr_line = line_wr && (upd_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (wr_line) begin
        tag_q[i]  <= upd_tag;
        data_q[i] <= upd_data;
      end
    end
  end

  // R9: a flush empties the partition one cycle later
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (vld_q == '0));

  // R7: an invalidate leaves no valid copy of that address
  p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en) |=>
      !(vld_q[$past(upd_idx)] && (tag_q[$past(upd_idx)] == $past(upd_tag))));

  // R2: a fill installs the word with its tag and data
  p_fill_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_en) |=>
      (vld_q[$past(upd_idx)] && (tag_q[$past(upd_idx)] == $past(upd_tag)) &&
       (data_q[$past(upd_idx)] == $past(upd_data))));

endmodule

// File: rtl/snc_lookup.sv
module snc_lookup #(
  parameter int NUM_PART = 7,
  parameter int DATA_W   = 32,
  parameter int STREAM_W = 3
) (
  input  logic [STREAM_W-1:0] stream,
  input  logic [NUM_PART-1:0] hit_vec,
  input  logic [DATA_W-1:0]   part_data [NUM_PART],
  output logic                lk_hit,
  output logic [DATA_W-1:0]   lk_data
);

  localparam int CNT_W = $clog2(NUM_PART + 1);

  logic [CNT_W-1:0]  hit_cnt;
  logic [DATA_W-1:0] any_data;
  logic              sel_hit;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    hit_cnt  = '0;
    any_data = '0;
    sel_hit  = 1'b0;
    sel_data = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (hit_vec[p]) begin
        hit_cnt  = hit_cnt + CNT_W'(1);
        any_data = any_data | part_data[p];
      end
      if (stream == STREAM_W'(p + 1)) begin
        sel_hit  = hit_vec[p];
        sel_data = part_data[p];
      end
    end
  end

  // stream 0 trusts a copy only when exactly one partition holds it
  always_comb begin
    if (stream == '0) begin
      lk_hit  = (hit_cnt == CNT_W'(1));
      lk_data = any_data;
    end else begin
      lk_hit  = sel_hit;
      lk_data = sel_data;
    end
  end

endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STREAM_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [STREAM_W-1:0] req_stream,
  input  logic                lk_hit,
  input  logic [DATA_W-1:0]   lk_data,
  output logic                resp_valid,
  output logic [DATA_W-1:0]   resp_rdata,
  output logic                mem_req_valid,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   upd_addr,
  output logic [DATA_W-1:0]   upd_data,
  output logic [STREAM_W-1:0] upd_stream,
  output logic                fill_go,
  output logic                inv_go
);

  snc_state_e state_q, state_d;
  logic       resp_v_q, resp_v_d;
  logic       mreq_v_q, mreq_v_d;
  logic [DATA_W-1:0]   resp_d_q, resp_d_d;
  logic [ADDR_W-1:0]   lat_a_q;
  logic [DATA_W-1:0]   lat_d_q;
  logic [STREAM_W-1:0] lat_s_q;
  logic                lat_w_q;
  logic                cap_en;
  logic                accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d    = state_q;
    resp_v_d   = 1'b0;
    resp_d_d   = resp_d_q;
    mreq_v_d   = 1'b0;
    cap_en     = 1'b0;
    fill_go    = 1'b0;
    inv_go     = 1'b0;
    upd_addr   = req_addr;
    upd_data   = req_wdata;
    upd_stream = req_stream;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            cap_en   = 1'b1;
            mreq_v_d = 1'b1;
            state_d  = ST_WAIT;
            if (req_stream != '0) fill_go = 1'b1;
            else                  inv_go  = 1'b1;
          end else if (lk_hit) begin
            resp_v_d = 1'b1;
            resp_d_d = lk_data;
          end else begin
            cap_en   = 1'b1;
            mreq_v_d = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        upd_addr   = lat_a_q;
        upd_data   = mem_rdata;
        upd_stream = lat_s_q;
        if (mem_ack) begin
          state_d = ST_IDLE;
          if (!lat_w_q) begin
            resp_v_d = 1'b1;
            resp_d_d = mem_rdata;
            fill_go  = (lat_s_q != '0);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      resp_v_q <= 1'b0;
      mreq_v_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resp_v_q <= resp_v_d;
      mreq_v_q <= mreq_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (resp_v_d) resp_d_q <= resp_d_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      lat_a_q <= req_addr;
      lat_d_q <= req_wdata;
      lat_s_q <= req_stream;
      lat_w_q <= req_write;
    end
  end

  assign resp_valid    = resp_v_q;
  assign resp_rdata    = resp_d_q;
  assign mem_req_valid = mreq_v_q;
  assign mem_req_write = lat_w_q;
  assign mem_req_addr  = lat_a_q;
  assign mem_req_wdata = lat_d_q;

  // R8: next-level request lasts one cycle
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R8: request side is closed while a next-level access is in flight
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R10: a response follows an accepted read or a next-level completion
  p_resp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready && !req_write) || $past(mem_ack)));

  // R6: a store produces no response
  p_write_no_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !resp_valid);

endmodule

// File: rtl/snc_array.sv
module snc_array #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PART = 7,
  parameter int LINES    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [DATA_W-1:0]                  req_wdata,
  input  logic [$clog2(NUM_PART+1)-1:0]      req_stream,
  output logic                               resp_valid,
  output logic [DATA_W-1:0]                  resp_rdata,
  input  logic                               flush_valid,
  input  logic [$clog2(NUM_PART+1)-1:0]      flush_stream,
  output logic                               mem_req_valid,
  output logic                               mem_req_write,
  output logic [ADDR_W-1:0]                  mem_req_addr,
  output logic [DATA_W-1:0]                  mem_req_wdata,
  input  logic                               mem_ack,
  input  logic [DATA_W-1:0]                  mem_rdata
);

  localparam int STREAM_W = $clog2(NUM_PART + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [NUM_PART-1:0] hit_vec;
  logic [DATA_W-1:0]   part_data [NUM_PART];
  logic                lk_hit;
  logic [DATA_W-1:0]   lk_data;
  logic [ADDR_W-1:0]   upd_addr;
  logic [DATA_W-1:0]   upd_data;
  logic [STREAM_W-1:0] upd_stream;
  logic                fill_go;
  logic                inv_go;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    logic fill_sel, flush_sel;
    assign fill_sel  = fill_go && (upd_stream == STREAM_W'(p + 1));
    assign flush_sel = flush_valid && (flush_stream == STREAM_W'(p + 1));
    snc_part #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LINES  (LINES)
    ) u_part (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .lk_addr  (req_addr),
      .lk_hit   (hit_vec[p]),
      .lk_data  (part_data[p]),
      .fill_en  (fill_sel),
      .inv_en   (inv_go),
      .flush_en (flush_sel),
      .upd_addr (upd_addr),
      .upd_data (upd_data)
    );
  end

  snc_lookup #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W),
    .STREAM_W (STREAM_W)
  ) u_lookup (
    .stream    (req_stream),
    .hit_vec   (hit_vec),
    .part_data (part_data),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data)
  );

  snc_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STREAM_W (STREAM_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_stream    (req_stream),
    .lk_hit        (lk_hit),
    .lk_data       (lk_data),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .upd_addr      (upd_addr),
    .upd_data      (upd_data),
    .upd_stream    (upd_stream),
    .fill_go       (fill_go),
    .inv_go        (inv_go)
  );

  // R4: an accepted read hit answers next cycle without touching memory
  p_hit_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_ready && !req_write && lk_hit) |=> (resp_valid && !mem_req_valid));

  // R5: a stream 0 read seen by several partitions goes to the next level
  p_s0_multi_miss_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_ready && !req_write && (req_stream == '0) &&
     ($countones(hit_vec) > 1)) |=> (mem_req_valid && !resp_valid));

endmodule

// File: tb/snc_array_tb.sv
module snc_array_tb_top;

  localparam int AW      = 8;
  localparam int DW      = 32;
  localparam int MEM_LAT = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [2:0]    req_stream;
  logic          resp_valid;
  logic [DW-1:0] resp_rdata;
  logic          flush_valid;
  logic [2:0]    flush_stream;
  logic          mem_req_valid;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  snc_array dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_stream    (req_stream),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .flush_valid   (flush_valid),
    .flush_stream  (flush_stream),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // ---------------- next-level memory model, fixed latency ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int            n_mem_req = 0;
  int            ovl_err   = 0;
  bit            mm_busy;
  int            mm_cnt;
  logic [AW-1:0] mm_addr;
  bit            prev_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      mm_busy   <= 1'b0;
      mm_cnt    <= 0;
      mm_addr   <= '0;
      prev_req  <= 1'b0;
    end else begin
      mem_ack  <= 1'b0;
      prev_req <= mem_req_valid;
      if (mem_req_valid) begin
        if (mm_busy || prev_req) ovl_err <= ovl_err + 1;
        n_mem_req <= n_mem_req + 1;
        if (mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
        mm_busy <= 1'b1;
        mm_cnt  <= MEM_LAT;
        mm_addr <= mem_req_addr;
      end else if (mm_busy) begin
        if (mm_cnt <= 2) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mm_addr];
          mm_busy   <= 1'b0;
        end else begin
          mm_cnt <= mm_cnt - 1;
        end
      end
    end
  end

  // ---------------- reference model of the partitions ----------------
  bit          m_v [1:7][0:3];
  logic [5:0]  m_t [1:7][0:3];
  logic [31:0] m_d [1:7][0:3];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear(input int s);
    for (int i = 0; i < 4; i++) m_v[s][i] = 1'b0;
  endtask

  task automatic do_req(input bit wr, input logic [2:0] s, input logic [AW-1:0] a,
                        input logic [31:0] d, input string tag);
    bit          exp_hit;
    logic [31:0] exp_d;
    int          hits;
    int          idx;
    int          nreq0;
    int          guard;
    idx   = int'(a[1:0]);
    hits  = 0;
    exp_d = '0;
    if (s != 0) begin
      exp_hit = m_v[s][idx] && (m_t[s][idx] == a[7:2]);
      exp_d   = m_d[s][idx];
    end else begin
      for (int k = 1; k <= 7; k++) begin
        if (m_v[k][idx] && (m_t[k][idx] == a[7:2])) begin
          hits++;
          exp_d = m_d[k][idx];
        end
      end
      exp_hit = (hits == 1);
    end
    if (wr) exp_hit = 1'b0;
    if (!exp_hit) exp_d = wr ? d : mem[a];

    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = a;
    req_wdata  = d;
    req_stream = s;
    guard = 0;
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    nreq0 = n_mem_req;
    @(negedge clk);
    req_valid = 1'b0;

    if (wr) begin
      chk(!req_ready && !resp_valid, tag, "store holds ready low, no response (R8)",
          {30'd0, req_ready, resp_valid}, 32'd0);
      guard = 0;
      while (!req_ready && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      chk(mem[a] == d, tag, "write-through data", mem[a], d);
      chk(n_mem_req == nreq0 + 1, tag, "store next-level request count",
          32'(n_mem_req - nreq0), 32'd1);
      if (s != 0) begin
        m_v[s][idx] = 1'b1;
        m_t[s][idx] = a[7:2];
        m_d[s][idx] = d;
      end else begin
        for (int k = 1; k <= 7; k++)
          if (m_t[k][idx] == a[7:2]) m_v[k][idx] = 1'b0;
      end
    end else if (exp_hit) begin
      chk(resp_valid && resp_rdata == exp_d, tag, "hit data one cycle after accept (R10)",
          resp_valid ? resp_rdata : 32'hdead_beef, exp_d);
      @(negedge clk);
      chk(n_mem_req == nreq0, tag, "hit made no next-level request",
          32'(n_mem_req - nreq0), 32'd0);
    end else begin
      guard = 0;
      while (!resp_valid && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      chk(resp_valid && resp_rdata == exp_d, tag, "miss data from next level",
          resp_valid ? resp_rdata : 32'hdead_beef, exp_d);
      chk(n_mem_req == nreq0 + 1, tag, "miss next-level request count",
          32'(n_mem_req - nreq0), 32'd1);
      if (s != 0) begin
        m_v[s][idx] = 1'b1;
        m_t[s][idx] = a[7:2];
        m_d[s][idx] = exp_d;
      end
    end
  endtask

  task automatic do_flush(input logic [2:0] s);
    @(negedge clk);
    flush_valid  = 1'b1;
    flush_stream = s;
    @(negedge clk);
    flush_valid  = 1'b0;
    if (s != 0) model_clear(int'(s));
  endtask

  // checks whether a read is a next-level miss, by request count only
  task automatic expect_miss(input logic [2:0] s, input logic [AW-1:0] a, input string tag);
    int n0;
    n0 = n_mem_req;
    do_req(1'b0, s, a, 32'd0, tag);
    chk(n_mem_req == n0 + 1, tag, "read expected to miss", 32'(n_mem_req - n0), 32'd1);
  endtask

  task automatic expect_hit(input logic [2:0] s, input logic [AW-1:0] a, input string tag);
    int n0;
    n0 = n_mem_req;
    do_req(1'b0, s, a, 32'd0, tag);
    chk(n_mem_req == n0, tag, "read expected to hit", 32'(n_mem_req - n0), 32'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < (1 << AW); i++) mem[i] = (i * 32'h9e37_79b1) ^ 32'ha5a5_0000;
    for (int s = 1; s <= 7; s++) model_clear(s);
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_write    = 1'b0;
    req_addr     = '0;
    req_wdata    = '0;
    req_stream   = '0;
    flush_valid  = 1'b0;
    flush_stream = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: state after reset
    chk(req_ready && !resp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'd0, req_ready, resp_valid, mem_req_valid}, 32'h4);

    // R2: miss fills the selected partition, repeat hits
    expect_miss(3'd1, 8'h10, "R2");
    expect_hit (3'd1, 8'h10, "R2");

    // R3: other nonzero streams do not see partition 1
    expect_miss(3'd2, 8'h10, "R3");

    // R5: held by partitions 1 and 2 -> stream 0 goes to memory
    expect_miss(3'd0, 8'h10, "R5");
    // R5: held nowhere -> miss, and no allocation on stream 0
    expect_miss(3'd0, 8'h24, "R5");
    expect_miss(3'd0, 8'h24, "R5");

    // R4: exactly one holder -> stream 0 hit
    expect_miss(3'd3, 8'h31, "R4");
    expect_hit (3'd0, 8'h31, "R4");

    // R6: private store updates its own partition, others keep their copy
    do_req(1'b1, 3'd1, 8'h10, 32'h1234_5678, "R6");
    expect_hit(3'd1, 8'h10, "R6");
    expect_hit(3'd2, 8'h10, "R6");
    // R8: stream 0 sees two holders, reads memory, gets the stored word
    expect_miss(3'd0, 8'h10, "R8");

    // R7: stream 0 store removes copies everywhere
    do_req(1'b1, 3'd0, 8'h31, 32'hcafe_0031, "R7");
    expect_miss(3'd3, 8'h31, "R7");

    // R11: direct-mapped conflicts within one stream
    expect_miss(3'd4, 8'h05, "R11");
    expect_miss(3'd4, 8'h06, "R11");
    expect_hit (3'd4, 8'h05, "R11");
    expect_miss(3'd4, 8'h09, "R11");
    expect_miss(3'd4, 8'h05, "R11");
    expect_hit (3'd4, 8'h06, "R11");

    // R9: flush one partition only; flush of 0 does nothing
    expect_miss(3'd5, 8'h0c, "R9");
    expect_miss(3'd6, 8'h0c, "R9");
    do_flush(3'd5);
    expect_miss(3'd5, 8'h0c, "R9");
    expect_hit (3'd6, 8'h0c, "R9");
    do_flush(3'd0);
    expect_hit (3'd6, 8'h0c, "R9");

    // R10: random mix of streams, loads, stores and flushes
    for (int n = 0; n < 400; n++) begin
      logic [2:0]    rs;
      logic [AW-1:0] ra;
      bit            rw;
      rs = 3'($urandom_range(7, 0));
      ra = AW'($urandom_range(23, 0));
      rw = ($urandom_range(3, 0) == 0);
      if ($urandom_range(19, 0) == 0) do_flush(3'($urandom_range(7, 0)));
      do_req(rw, rs, ra, $urandom, "R10");
    end

    // R8: single outstanding request, pulse requests
    chk(ovl_err == 0, "R8", "overlapping or stretched next-level requests",
        32'(ovl_err), 32'd0);

    done = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule